// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block receives 28 asynchronous external interrupt lines and turns them into latched pending requests. Each line is first brought into the clock domain by a two-stage synchroniser. A trigger detector then fires on a low level, a high level, a falling edge, a rising edge or either edge, as programmed. Two neighbouring lines always share one trigger-mode field. A line that fires sets its bit in a pending register, and software acknowledges it by writing ones to that register.

A mask register decides which pending lines may raise a request. Pending, unmasked lines are OR-ed into four group request outputs of unequal size: lines 0-3, 4-11, 12-19 and 20-27. A downstream vectored interrupt controller consumes these outputs. Software reaches the block through a plain 32-bit register port that has a word address, a write strobe and registered read data.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While reset is held (synchronous, active high), and on the first cycle after it, the pending bits are 0, every mask bit is 1 (mask reads 0x0FFFFFFF), both trigger-mode registers read 0 and all group outputs are 0.
- R2: The mask register (word address 2) reads back bits 27:0 exactly as written, and bits 31:28 always read as 0. A mask bit of 1 suppresses its line.
- R3: Writing the pending register (word address 3) clears every pending bit whose data bit is 1. A bit written as 0 leaves its pending bit as it was.
- R4: Lines 0-15 take their trigger mode from word address 0, with line n at bits (n/2)*4. Lines 16-27 take it from word address 1, with line n at bits ((n-16)/2)*4. Only the low 3 bits of each 4-bit field are stored. Bit 3 of each field, and bits 31:24 of word address 1, read as 0.
- R5: Mode 000 triggers on a low level and mode 001 on a high level. While the level is active, the pending bit is set again on every clock, so a clear takes effect only after the input goes inactive.
- R6: Mode 01x triggers on a falling edge, 10x on a rising edge and 11x on both edges. An edge is found by comparing the synchronised input with its value one clock earlier. The pending bit then stays set until software clears it.
- R7: When a trigger and a clear write to the same line fall on the same clock, the trigger wins and the pending bit stays set.
- R8: Group output 0 covers lines 0-3, 1 covers 4-11, 2 covers 12-19 and 3 covers 20-27. A group output is 1 exactly when some line in its range is pending and unmasked.
- R9: A change on an input line sets its pending bit on the third rising clock edge after the change. The group output follows on the fourth edge. Read data appears one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pins | input | 28 | Asynchronous external interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 mode low, 1 mode high, 2 mask, 3 pending |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| grp_irq | output | 4 | Group request outputs toward the vectored controller |

## Verification
A change on an input line reaches its pending bit at the third rising edge after the change, the group output one edge later, and the pending bit in read data one clock after the pending address is presented. In the main sweep, every line and every 3-bit mode code is driven in turn. The bench then waits six clocks before it reads registers or samples outputs, so every result has settled. Two checks instead sample on exact edges: the latency check looks at the group output just after the third and the fourth edge, and the coincidence check lands the clear write on the very edge that latches the trigger. All inputs are driven at falling edges, and all outputs are sampled there too.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int LINES   = 28;
  localparam int GROUPS  = 4;
  localparam int MODE_W  = 3;
  localparam int FIELD_W = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;

  typedef enum logic [1:0] {
    SEL_CFG_LO = 2'd0,
    SEL_CFG_HI = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_PEND   = 2'd3
  } reg_sel_e;

  // first line of each group; groups are contiguous and ascend
  function automatic int group_first(input int g);
    case (g)
      0:       return 0;
      1:       return 4;
      2:       return 12;
      default: return 20;
    endcase
  endfunction

  function automatic int group_last(input int g, input int lines);
    return (g == GROUPS - 1) ? lines - 1 : group_first(g + 1) - 1;
  endfunction

  // trigger condition for one line given its mode code
  function automatic logic trig_hit(input logic [MODE_W-1:0] mode,
                                    input logic cur, input logic prev);
    logic hit;
    case (mode[2:1])
      2'b00:   hit = mode[0] ? cur : ~cur;
      2'b01:   hit = prev & ~cur;
      2'b10:   hit = ~prev & cur;
      default: hit = prev ^ cur;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/ext_irq_capture.sv
module ext_irq_capture #(
  parameter int LINES  = ext_irq_pkg::LINES,
  parameter int MODE_W = ext_irq_pkg::MODE_W,
  localparam int PAIRS = LINES / 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LINES-1:0]              cur,
  input  logic [LINES-1:0]              prev,
  input  logic [PAIRS-1:0][MODE_W-1:0]  pair_mode,
  input  logic [LINES-1:0]              clr,
  output logic [LINES-1:0]              pend
);
  logic [LINES-1:0] hit;
  logic [LINES-1:0] pend_q;

  for (genvar n = 0; n < LINES; n++) begin : g_line
    assign hit[n] = ext_irq_pkg::trig_hit(pair_mode[n/2], cur[n], prev[n]);
  end

  // a trigger in the same cycle as a clear keeps the bit set
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr) | hit;
  end

  assign pend = pend_q;
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs #(
  parameter int LINES   = ext_irq_pkg::LINES,
  parameter int DATA_W  = ext_irq_pkg::DATA_W,
  parameter int FIELD_W = ext_irq_pkg::FIELD_W,
  parameter int MODE_W  = ext_irq_pkg::MODE_W,
  parameter int ADDR_W  = ext_irq_pkg::ADDR_W,
  localparam int PAIRS   = LINES / 2,
  localparam int PER_REG = DATA_W / FIELD_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic [LINES-1:0]              pend,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [LINES-1:0]              mask,
  output logic [LINES-1:0]              clr,
  output logic [PAIRS-1:0][MODE_W-1:0]  pair_mode
);
  import ext_irq_pkg::*;

  reg_sel_e                     sel;
  logic [LINES-1:0]             mask_q;
  logic [PAIRS-1:0][MODE_W-1:0] mode_q;
  logic [DATA_W-1:0]            cfg_lo;
  logic [DATA_W-1:0]            cfg_hi;
  logic [DATA_W-1:0]            rd_next;
  logic [DATA_W-1:0]            rdata_q;
  logic                         unused_wbits;

  assign sel          = reg_sel_e'(bus_addr);
  assign unused_wbits = ^bus_wdata;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam reg_sel_e P_SEL = (p < PER_REG) ? SEL_CFG_LO : SEL_CFG_HI;
    localparam int       P_LSB = (p % PER_REG) * FIELD_W;
    always_ff @(posedge clk) begin
      if (rst)                          mode_q[p] <= '0;
      else if (bus_wr && sel == P_SEL)  mode_q[p] <= bus_wdata[P_LSB +: MODE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            mask_q <= '1;
    else if (bus_wr && sel == SEL_MASK) mask_q <= bus_wdata[LINES-1:0];
  end

  assign clr = (bus_wr && sel == SEL_PEND) ? bus_wdata[LINES-1:0] : '0;

  always_comb begin
    cfg_lo = '0;
    cfg_hi = '0;
    for (int p = 0; p < PAIRS; p++) begin
      if (p < PER_REG) cfg_lo[(p % PER_REG)*FIELD_W +: MODE_W] = mode_q[p];
      else             cfg_hi[(p % PER_REG)*FIELD_W +: MODE_W] = mode_q[p];
    end
  end

  always_comb begin
    case (sel)
      SEL_CFG_LO: rd_next = cfg_lo;
      SEL_CFG_HI: rd_next = cfg_hi;
      SEL_MASK:   rd_next = {{(DATA_W-LINES){1'b0}}, mask_q};
      default:    rd_next = {{(DATA_W-LINES){1'b0}}, pend};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
  assign mask      = mask_q;
  assign pair_mode = mode_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int LINES   = ext_irq_pkg::LINES,
  parameter int GROUPS  = ext_irq_pkg::GROUPS,
  parameter int DATA_W  = ext_irq_pkg::DATA_W,
  parameter int FIELD_W = ext_irq_pkg::FIELD_W,
  parameter int MODE_W  = ext_irq_pkg::MODE_W,
  parameter int ADDR_W  = ext_irq_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  irq_pins,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [GROUPS-1:0] grp_irq
);
  localparam int PAIRS = LINES / 2;

  logic [LINES-1:0]             sync_cur;
  logic [LINES-1:0]             sync_prev;
  logic [LINES-1:0]             pend_q;
  logic [LINES-1:0]             mask_q;
  logic [LINES-1:0]             clr_vec;
  logic [PAIRS-1:0][MODE_W-1:0] pair_mode;
  logic [LINES-1:0]             live;
  logic [GROUPS-1:0]            grp_hit;
  logic [GROUPS-1:0]            grp_q;

  ext_irq_sync #(.W(LINES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (irq_pins),
    .cur  (sync_cur),
    .prev (sync_prev)
  );

  ext_irq_regs #(
    .LINES(LINES), .DATA_W(DATA_W), .FIELD_W(FIELD_W),
    .MODE_W(MODE_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend      (pend_q),
    .bus_rdata (bus_rdata),
    .mask      (mask_q),
    .clr       (clr_vec),
    .pair_mode (pair_mode)
  );

  ext_irq_capture #(.LINES(LINES), .MODE_W(MODE_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .cur       (sync_cur),
    .prev      (sync_prev),
    .pair_mode (pair_mode),
    .clr       (clr_vec),
    .pend      (pend_q)
  );

  assign live = pend_q & ~mask_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int FIRST = ext_irq_pkg::group_first(g);
    localparam int LAST  = ext_irq_pkg::group_last(g, LINES);
    assign grp_hit[g] = |live[LAST:FIRST];
  end

  always_ff @(posedge clk) begin
    if (rst) grp_q <= '0;
    else     grp_q <= grp_hit;
  end

  assign grp_irq = grp_q;
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int LINES  = 28,
  parameter int GROUPS = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [GROUPS-1:0] grp_irq,
  input logic [LINES-1:0]  mask_q,
  input logic [LINES-1:0]  pend_q
);
  logic [LINES-1:0] clr_vec;
  logic [LINES-1:0] keep_vec;
  logic             unused_wd;

  assign unused_wd = ^bus_wdata;
  assign clr_vec   = (bus_wr && bus_addr == 2'd3) ? bus_wdata[LINES-1:0] : '0;
  assign keep_vec  = pend_q & ~clr_vec;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (grp_irq == '0 && pend_q == '0 && (&mask_q))); // R1

  AST_MASK_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == 2'd2) |-> (bus_rdata[31:28] == 4'h0)); // R2

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (keep_vec != '0) |=> ((pend_q & $past(keep_vec)) == $past(keep_vec))); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == 2'd1) |-> (bus_rdata[31:24] == 8'h00 && (bus_rdata & 32'h0088_8888) == 32'h0)); // R4

  AST_FIELD_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == 2'd0) |-> ((bus_rdata & 32'h8888_8888) == 32'h0)); // R4

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |=> (grp_irq == '0)); // R8
endmodule

bind ext_irq_ctrl ext_irq_chk #(
  .LINES(LINES), .GROUPS(GROUPS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .grp_irq   (grp_irq),
  .mask_q    (mask_q),
  .pend_q    (pend_q)
);

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [27:0] irq_pins;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  grp_irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  ext_irq_ctrl u0 (
    .clk(clk), .rst(rst), .irq_pins(irq_pins), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .grp_irq(grp_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  function automatic bit trig(input int m, input bit o, input bit nw);
    if (m == 0) return !nw;
    if (m == 1) return nw;
    case (m >> 1)
      1:       return o & !nw;
      2:       return !o & nw;
      default: return o ^ nw;
    endcase
  endfunction

  function automatic int group_of(input int l);
    if (l < 4)  return 0;
    if (l < 12) return 1;
    if (l < 20) return 2;
    return 3;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; irq_pins = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    wait_cyc(4);
    check("R1 grp in reset", {28'd0, grp_irq}, 32'h0);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    rst = 1'b0;
    bus_read(2'd2, v); check("R1 mask reset", v, 32'h0FFF_FFFF);
    bus_read(2'd0, v); check("R1 cfg lo reset", v, 32'h0);
    bus_read(2'd1, v); check("R1 cfg hi reset", v, 32'h0);
    wait_cyc(4);
    // reset mode is low level and every pin is low
    bus_read(2'd3, v); check("R5 low level pending", v, 32'h0FFF_FFFF);
    check("R8 masked grp", {28'd0, grp_irq}, 32'h0);

    bus_write(2'd0, 32'hFFFF_FFFF); bus_read(2'd0, v); check("R4 cfg lo rsvd", v, 32'h7777_7777);
    bus_write(2'd1, 32'hFFFF_FFFF); bus_read(2'd1, v); check("R4 cfg hi rsvd", v, 32'h0077_7777);
    bus_write(2'd2, 32'hA5A5_A5A5); bus_read(2'd2, v); check("R2 mask a5", v, 32'h05A5_A5A5);
    bus_write(2'd2, 32'h1234_5678); bus_read(2'd2, v); check("R2 mask 78", v, 32'h0234_5678);
    bus_write(2'd2, 32'hFFFF_FFFF); bus_read(2'd2, v); check("R2 mask all", v, 32'h0FFF_FFFF);

    // all lines rising edge
    bus_write(2'd0, 32'h4444_4444);
    bus_write(2'd1, 32'h0044_4444);
    bus_write(2'd3, 32'h0FFF_FFFF);
    wait_cyc(6);
    bus_read(2'd3, v); check("R3 clear all", v, 32'h0);

    irq_pins = '1;
    wait_cyc(6);
    bus_read(2'd3, v); check("R6 rising all", v, 32'h0FFF_FFFF);
    check("R8 all masked", {28'd0, grp_irq}, 32'h0);
    bus_write(2'd3, 32'h0000_0005);
    bus_read(2'd3, v); check("R3 partial clear", v, 32'h0FFF_FFFA);
    bus_write(2'd3, 32'h0);
    bus_read(2'd3, v); check("R3 zero write", v, 32'h0FFF_FFFA);
    irq_pins = '0;
    bus_write(2'd3, 32'hFFFF_FFFF);
    wait_cyc(6);
    bus_read(2'd3, v); check("R6 no rise on fall", v, 32'h0);

    // exact latency on line 0
    bus_write(2'd2, 32'h0FFF_FFFE);
    @(negedge clk);
    irq_pins[0] = 1'b1;
    repeat (3) @(posedge clk);
    #2 check("R9 grp not before edge 4", {28'd0, grp_irq}, 32'h0);
    @(posedge clk);
    #2 check("R9 grp at edge 4", {28'd0, grp_irq}, 32'h1);
    bus_write(2'd3, 32'h1);
    bus_read(2'd3, v); check("R3 clear line 0", v, 32'h0);
    irq_pins[0] = 1'b0;
    bus_write(2'd2, 32'h0FFF_FFFF);

    // edge coinciding with clear write
    irq_pins[6] = 1'b1;
    wait_cyc(6);
    @(negedge clk);
    irq_pins[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h0000_0060;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_read(2'd3, v); check("R7 edge beats clear", v, 32'h0000_0020);
    irq_pins = '0;
    bus_write(2'd3, 32'h0FFF_FFFF);

    // sweep every line and every mode code
    for (int l = 0; l < 28; l++) begin
      for (int m = 0; m < 8; m++) begin
        logic [31:0] c0, c1, eb;
        int p;
        bit b, ea, eb2, lvl;
        p  = l / 2;
        c0 = 32'h4444_4444;
        c1 = 32'h0044_4444;
        if (p < 8) c0 = (c0 & ~(32'hF << (p*4))) | (32'(m) << (p*4));
        else       c1 = (c1 & ~(32'hF << ((p-8)*4))) | (32'(m) << ((p-8)*4));
        lvl = (m < 2);
        b   = (m == 0);
        eb  = 32'h1 << l;
        bus_write(2'd2, 32'h0FFF_FFFF);
        bus_write(2'd0, c0);
        bus_write(2'd1, c1);
        bus_read(p < 8 ? 2'd0 : 2'd1, v);
        check("R4 field readback", v, p < 8 ? c0 : c1);
        irq_pins = b ? '1 : '0;
        wait_cyc(6);
        bus_write(2'd3, 32'h0FFF_FFFF);
        wait_cyc(6);
        bus_read(2'd3, v); check("R5 R6 idle", v, 32'h0);
        bus_write(2'd2, 32'h0FFF_FFFF & ~eb);

        irq_pins[l] = ~b;
        wait_cyc(6);
        ea = trig(m, b, ~b);
        bus_read(2'd3, v); check("R5 R6 assert step", v, ea ? eb : 32'h0);
        check("R8 group map", {28'd0, grp_irq}, ea ? (32'h1 << group_of(l)) : 32'h0);
        bus_write(2'd3, eb);
        wait_cyc(6);
        bus_read(2'd3, v);
        check(lvl ? "R5 clear while active" : "R6 clear edge", v, lvl ? eb : 32'h0);

        irq_pins[l] = b;
        wait_cyc(6);
        eb2 = lvl ? 1'b1 : trig(m, ~b, b);
        bus_read(2'd3, v); check("R5 R6 release step", v, eb2 ? eb : 32'h0);
        bus_write(2'd3, eb);
        wait_cyc(6);
        bus_read(2'd3, v); check("R5 clear after release", v, 32'h0);
        check("R8 group idle", {28'd0, grp_irq}, 32'h0);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule